// File: doc/BRIEF.md
# Interrupt Pin Request and Remote-IRR Tracker

This block sits between a bank of interrupt input pins and the logic that routes interrupts to processors. Each clock it samples every raw pin, corrects it by the pin's polarity setting, and keeps one pending request per pin. Edge-triggered pins latch one request per active-going transition. Level-triggered pins follow the corrected level. They also carry a remote-IRR flag, which blocks further deliveries until an end-of-interrupt message releases it.

Pins that are ready to deliver compete for a single delivery slot, and the lowest pin index wins. The slot offers the winning pin index on a valid/ready handshake, and a pin counts as delivered when the slot captures it. End-of-interrupt messages carry a vector number. The block searches the per-pin vector settings and clears remote-IRR on the lowest-numbered pin that matches. If no pin matches, it raises a one-cycle error flag. The pin configuration (polarity, trigger mode, mask, vector) comes from an external register file. Choosing a destination and sending the interrupt happen downstream.

Top module: `irq_pin_tracker`

## Requirements
- R1: A pin's effective level is its raw level XOR its polarity bit. With polarity 1, a raw 0 is active and a raw 1 is inactive.
- R2: A level pin (trigger bit 1) whose effective level is 1 is captured into the delivery slot when it is unmasked and its remote-IRR is 0. dlv_valid_o rises at the second rising clock edge after the pin change is first sampled. Capture sets the pin's remote-IRR, and no further delivery of that pin happens while remote-IRR stays 1.
- R3: An edge pin (trigger bit 0) produces exactly one delivery for each 0-to-1 transition of its effective level that is sampled while the pin is unmasked, however long the level is held. A transition sampled while the pin is masked is discarded and is not delivered after a later unmask.
- R4: Delivering an edge pin leaves its remote-IRR at 0.
- R5: A masked level pin held active is not delivered. When the mask is later cleared while the level is still active, the pin is delivered and its remote-IRR is set.
- R6: A level pin whose effective level returns to 0 before it is delivered loses its request and is not delivered.
- R7: An end-of-interrupt clears remote-IRR only on the lowest-numbered pin whose vector equals the message vector. Higher-numbered pins with the same vector keep their remote-IRR.
- R8: If a level pin is still active and unmasked when its remote-IRR is cleared by an end-of-interrupt, it is delivered again.
- R9: An end-of-interrupt that matches no pin's vector changes no remote-IRR bit. It raises eoi_miss_o for exactly one cycle, starting at the clock edge that accepts the message. A matching message leaves eoi_miss_o at 0.
- R10: While dlv_valid_o is 1 and dlv_ready_i is 0, dlv_valid_o and dlv_pin_o hold their values.
- R11: When several pins are waiting, the lowest index is offered first and the others follow in index order.
- R12: After reset, dlv_valid_o, eoi_miss_o and every remote-IRR bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_raw_i | input | NUM_PINS | Raw interrupt pin levels |
| polarity_i | input | NUM_PINS | Per-pin polarity; 1 inverts the raw level |
| lvl_trig_i | input | NUM_PINS | Per-pin trigger mode; 1 level, 0 edge |
| mask_i | input | NUM_PINS | Per-pin mask; 1 blocks delivery |
| vector_i | input | NUM_PINS*VEC_W | Per-pin vector, pin i at bits [i*VEC_W +: VEC_W] |
| dlv_valid_o | output | 1 | Delivery request valid |
| dlv_ready_i | input | 1 | Downstream accepts the delivery request |
| dlv_pin_o | output | PIN_W | Index of the pin being delivered |
| eoi_valid_i | input | 1 | End-of-interrupt message strobe |
| eoi_vector_i | input | VEC_W | Vector carried by the end-of-interrupt |
| eoi_miss_o | output | 1 | One-cycle flag: end-of-interrupt matched no pin |
| remote_irr_o | output | NUM_PINS | Per-pin remote-IRR flags |

## Verification
The bench builds the block with NUM_PINS = 6 and VEC_W = 8. With only six pins, every pin can be given its own role: two level pins share a vector, one pin has inverted polarity, one is edge-triggered and one starts masked. This brings the shared-vector end-of-interrupt case and the lowest-index arbitration into reach with a few directed sequences. Holding dlv_ready_i low while two pins wait exercises slot stability and the order in which the waiting pins drain.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  localparam logic TRIG_EDGE  = 1'b0;
  localparam logic TRIG_LEVEL = 1'b1;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  onehot_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  // isolate lowest set bit
  assign onehot_o = req_i & ~(req_i - N'(1));
endmodule

// File: rtl/irq_pin_cell.sv
module irq_pin_cell
  import irq_trk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_raw_i,
  input  logic polarity_i,
  input  logic lvl_trig_i,
  input  logic mask_i,
  input  logic claim_i,
  input  logic eoi_clr_i,
  output logic want_o,
  output logic rirr_o
);
  logic eff, eff_q, rise;
  logic pend_q, pend_d;
  logic rirr_q, rirr_d;

  assign eff  = pin_raw_i ^ polarity_i;
  assign rise = eff & ~eff_q;

  always_comb begin
    if (lvl_trig_i == TRIG_LEVEL) pend_d = eff;
    else                          pend_d = (pend_q & ~claim_i) | (rise & ~mask_i);
  end

  always_comb begin
    rirr_d = rirr_q;
    if (claim_i && lvl_trig_i == TRIG_LEVEL) rirr_d = 1'b1;
    else if (eoi_clr_i)                      rirr_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_q  <= 1'b0;
      pend_q <= 1'b0;
      rirr_q <= 1'b0;
    end else begin
      eff_q  <= eff;
      pend_q <= pend_d;
      rirr_q <= rirr_d;
    end
  end

  // edge: mask is applied at capture; level: mask and remote-IRR gate the request
  assign want_o = (lvl_trig_i == TRIG_LEVEL) ? (pend_q & ~mask_i & ~rirr_q) : pend_q;
  assign rirr_o = rirr_q;

  p_rirr_set_by_claim_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rirr_q) |-> $past(claim_i && lvl_trig_i == TRIG_LEVEL));

  p_eoi_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_clr_i && !claim_i) |=> !rirr_q);

  p_edge_keeps_rirr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_trig_i == TRIG_EDGE && !rirr_q && !$isunknown(claim_i)) |=> !$rose(rirr_q));
endmodule

// File: rtl/irq_eoi_match.sv
module irq_eoi_match #(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  parameter int PIN_W    = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      eoi_valid_i,
  input  logic [VEC_W-1:0]          eoi_vector_i,
  input  logic [NUM_PINS*VEC_W-1:0] vector_i,
  output logic [NUM_PINS-1:0]       clr_o,
  output logic                      miss_o
);
  logic [NUM_PINS-1:0] hit, first_hit;
  logic                any_hit;
  logic [PIN_W-1:0]    hit_idx;
  logic                miss_q;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_cmp
    assign hit[g] = (vector_i[g*VEC_W +: VEC_W] == eoi_vector_i);
  end

  irq_lsb_pick #(.N(NUM_PINS), .IW(PIN_W)) u_pick (
    .req_i   (hit),
    .found_o (any_hit),
    .idx_o   (hit_idx),
    .onehot_o(first_hit)
  );

  assign clr_o = eoi_valid_i ? first_hit : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) miss_q <= 1'b0;
    else         miss_q <= eoi_valid_i & ~any_hit;
  end

  assign miss_o = miss_q;

  p_clr_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));

  p_miss_only_after_eoi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_q |-> $past(eoi_valid_i));

  p_miss_means_no_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_valid_i && !any_hit) |-> (clr_o == '0));

  p_idx_in_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_hit |-> (int'(hit_idx) < NUM_PINS));
endmodule

// File: rtl/irq_dlv_slot.sv
module irq_dlv_slot #(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] want_i,
  input  logic                ready_i,
  output logic                valid_o,
  output logic [PIN_W-1:0]    pin_o,
  output logic [NUM_PINS-1:0] claim_o
);
  logic             valid_q;
  logic [PIN_W-1:0] pin_q;
  logic             load, found;
  logic [PIN_W-1:0] pick_idx;
  logic [NUM_PINS-1:0] pick_oh;

  irq_lsb_pick #(.N(NUM_PINS), .IW(PIN_W)) u_pick (
    .req_i   (want_i),
    .found_o (found),
    .idx_o   (pick_idx),
    .onehot_o(pick_oh)
  );

  // refill when empty or draining this cycle
  assign load    = ~valid_q | ready_i;
  assign claim_o = (load && found) ? pick_oh : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pin_q   <= '0;
    end else if (load) begin
      valid_q <= found;
      if (found) pin_q <= pick_idx;
    end
  end

  assign valid_o = valid_q;
  assign pin_o   = pin_q;

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(pin_q)));

  p_claim_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(claim_o));

  p_pin_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (int'(pin_q) < NUM_PINS));
endmodule

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker
  import irq_trk_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  localparam int PIN_W   = idx_width(NUM_PINS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PINS-1:0]       pin_raw_i,
  input  logic [NUM_PINS-1:0]       polarity_i,
  input  logic [NUM_PINS-1:0]       lvl_trig_i,
  input  logic [NUM_PINS-1:0]       mask_i,
  input  logic [NUM_PINS*VEC_W-1:0] vector_i,
  output logic                      dlv_valid_o,
  input  logic                      dlv_ready_i,
  output logic [PIN_W-1:0]          dlv_pin_o,
  input  logic                      eoi_valid_i,
  input  logic [VEC_W-1:0]          eoi_vector_i,
  output logic                      eoi_miss_o,
  output logic [NUM_PINS-1:0]       remote_irr_o
);
  logic [NUM_PINS-1:0] want, claim, eoi_clr, rirr;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    irq_pin_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_raw_i (pin_raw_i[g]),
      .polarity_i(polarity_i[g]),
      .lvl_trig_i(lvl_trig_i[g]),
      .mask_i    (mask_i[g]),
      .claim_i   (claim[g]),
      .eoi_clr_i (eoi_clr[g]),
      .want_o    (want[g]),
      .rirr_o    (rirr[g])
    );
  end

  irq_dlv_slot #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .want_i (want),
    .ready_i(dlv_ready_i),
    .valid_o(dlv_valid_o),
    .pin_o  (dlv_pin_o),
    .claim_o(claim)
  );

  irq_eoi_match #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .PIN_W(PIN_W)) u_eoi (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .eoi_valid_i (eoi_valid_i),
    .eoi_vector_i(eoi_vector_i),
    .vector_i    (vector_i),
    .clr_o       (eoi_clr),
    .miss_o      (eoi_miss_o)
  );

  assign remote_irr_o = rirr;

  p_miss_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_miss_o |=> (!eoi_miss_o || $past(eoi_valid_i)));

  p_miss_keeps_rirr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_valid_i && eoi_clr == '0 && claim == '0) |=> $stable(remote_irr_o));
endmodule

// File: tb/sim_irq_pin_tracker.sv
module sim_irq_pin_tracker;
  localparam int NP = 6;
  localparam int VW = 8;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] raw, pol, lvl, msk;
  logic [NP*VW-1:0] vec;
  logic          rdy, eoi_v, dlv_valid, miss;
  logic [VW-1:0] eoi_vec;
  logic [PW-1:0] dlv_pin;
  logic [NP-1:0] rirr;

  int tests = 0, fails = 0;
  int cnt[NP];
  int log_pin[32];
  int nlog = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_pin_tracker #(.NUM_PINS(NP), .VEC_W(VW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_raw_i(raw), .polarity_i(pol),
    .lvl_trig_i(lvl), .mask_i(msk), .vector_i(vec),
    .dlv_valid_o(dlv_valid), .dlv_ready_i(rdy), .dlv_pin_o(dlv_pin),
    .eoi_valid_i(eoi_v), .eoi_vector_i(eoi_vec), .eoi_miss_o(miss),
    .remote_irr_o(rirr)
  );

  always @(posedge clk) begin
    if (rst_n && dlv_valid && rdy) begin
      cnt[dlv_pin] = cnt[dlv_pin] + 1;
      if (nlog < 32) log_pin[nlog] = int'(dlv_pin);
      nlog = nlog + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_eoi(input logic [VW-1:0] v);
    @(negedge clk);
    eoi_v = 1'b1; eoi_vec = v;
    @(negedge clk);
    eoi_v = 1'b0;
  endtask

  task automatic t_reset;
    chk("R12 valid", int'(dlv_valid), 0);
    chk("R12 miss", int'(miss), 0);
    chk("R12 rirr", int'(rirr), 0);
    step(4);
    chk("R1 inverted pin idle", cnt[1], 0);
  endtask

  task automatic t_level;
    raw[0] = 1'b1;
    step(1);
    chk("R2 not yet valid", int'(dlv_valid), 0);
    step(1);
    chk("R2 valid latency", int'(dlv_valid), 1);
    chk("R2 pin index", int'(dlv_pin), 0);
    step(4);
    chk("R2 single delivery", cnt[0], 1);
    chk("R2 rirr set", int'(rirr[0]), 1);
    send_eoi(8'h30);
    step(5);
    chk("R8 redelivery", cnt[0], 2);
    chk("R8 rirr set again", int'(rirr[0]), 1);
    raw[0] = 1'b0;
    step(2);
    send_eoi(8'h30);
    step(5);
    chk("R7 eoi no redelivery", cnt[0], 2);
    chk("R7 rirr cleared", int'(rirr[0]), 0);
  endtask

  task automatic t_polarity;
    raw[1] = 1'b0;
    step(5);
    chk("R1 active low delivered", cnt[1], 1);
    raw[1] = 1'b1;
    step(2);
    send_eoi(8'h31);
    step(4);
    chk("R1 inactive after eoi", cnt[1], 1);
    chk("R1 rirr clear", int'(rirr[1]), 0);
  endtask

  task automatic t_edge;
    raw[3] = 1'b1;
    step(6);
    chk("R3 one delivery", cnt[3], 1);
    chk("R4 edge rirr", int'(rirr[3]), 0);
    step(4);
    chk("R3 held high once", cnt[3], 1);
    raw[3] = 1'b0;
    step(1);
    raw[3] = 1'b1;
    step(6);
    chk("R3 second edge", cnt[3], 2);
    raw[3] = 1'b0;
    msk[3] = 1'b1;
    step(1);
    raw[3] = 1'b1;
    step(2);
    msk[3] = 1'b0;
    step(6);
    chk("R3 masked edge lost", cnt[3], 2);
    raw[3] = 1'b0;
    step(2);
  endtask

  task automatic t_mask;
    raw[5] = 1'b1;
    step(6);
    chk("R5 masked none", cnt[5], 0);
    chk("R5 masked rirr", int'(rirr[5]), 0);
    msk[5] = 1'b0;
    step(6);
    chk("R5 unmask delivers", cnt[5], 1);
    chk("R5 rirr set", int'(rirr[5]), 1);
    raw[5] = 1'b0;
    step(2);
    send_eoi(8'h35);
    step(3);
    chk("R7 rirr5 cleared", int'(rirr[5]), 0);
  endtask

  task automatic t_drop;
    msk[5] = 1'b1;
    raw[5] = 1'b1;
    step(3);
    raw[5] = 1'b0;
    step(2);
    msk[5] = 1'b0;
    step(6);
    chk("R6 dropped request", cnt[5], 1);
  endtask

  task automatic t_shared;
    int base;
    base = nlog;
    rdy = 1'b0;
    raw[2] = 1'b1;
    raw[4] = 1'b1;
    step(2);
    chk("R11 lowest offered", int'(dlv_pin), 2);
    chk("R10 valid up", int'(dlv_valid), 1);
    step(4);
    chk("R10 valid held", int'(dlv_valid), 1);
    chk("R10 pin held", int'(dlv_pin), 2);
    rdy = 1'b1;
    step(6);
    chk("R11 pin2 count", cnt[2], 1);
    chk("R11 pin4 count", cnt[4], 1);
    chk("R11 first", log_pin[base], 2);
    chk("R11 second", log_pin[base+1], 4);
    raw[2] = 1'b0;
    raw[4] = 1'b0;
    step(2);
    send_eoi(8'h40);
    chk("R9 no miss on match", int'(miss), 0);
    step(1);
    chk("R7 lowest match cleared", int'(rirr), 6'b010000);
    send_eoi(8'h40);
    step(1);
    chk("R7 higher match kept", int'(rirr), 6'b010000);
    @(negedge clk);
    eoi_v = 1'b1; eoi_vec = 8'h77;
    @(negedge clk);
    eoi_v = 1'b0;
    chk("R9 miss pulse", int'(miss), 1);
    step(1);
    chk("R9 miss one cycle", int'(miss), 0);
    chk("R9 rirr unchanged", int'(rirr), 6'b010000);
    vec[2*VW +: VW] = 8'h42;
    send_eoi(8'h40);
    step(1);
    chk("R7 pin4 cleared", int'(rirr), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) cnt[i] = 0;
    pol = 6'b000010;
    raw = pol;
    lvl = 6'b110111;
    msk = 6'b100000;
    vec = {8'h35, 8'h40, 8'h33, 8'h40, 8'h31, 8'h30};
    rdy = 1'b1;
    eoi_v = 1'b0;
    eoi_vec = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_level();
    t_polarity();
    t_edge();
    t_mask();
    t_drop();
    t_shared();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule